// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block passes a data word between two ports in both directions. Each direction has its own storage register, a level-sensitive pass-through enable, a direction clock and an output enable. With these controls a direction can run in one of three modes:

- **Transparent:** the far port follows the near port.
- **Holding:** the far port keeps its stored word.
- **Clocked:** a new word is captured on each falling edge of the direction clock.

The block runs on a fast system clock. It samples the direction clocks and pass-through enables as ordinary synchronous inputs. Each three-state port is modelled as a data vector plus a drive-enable bit.

The A-to-B output enable is active high. The B-to-A output enable is active low. Both directions work at the same time and do not affect each other.

Top module: `dual_path_xcvr`

## Requirements
- R1: Data width is the parameter `WIDTH` (default 18). The two directions share no state.
- R2: While `abPass` is 1, `bOut` equals `aIn` combinationally, in the same system cycle.
- R3: While `abPass` is 0 and `abClk` is sampled at a constant level on consecutive system edges, `bOut` keeps its stored value whatever `aIn` does.
- R4: A falling edge of `abClk` is detected when a rising system edge samples 0 after the previous edge sampled 1. With `abPass` 0, that same edge stores `aIn`, and `bOut` shows it right after the edge.
- R5: `bDrive` equals `abOutEn` (active high). The output enable never changes the stored word.
- R6: The B-to-A direction behaves like R2 to R4 using `baPass`, `baClk`, `bIn` and `aOut`. `aDrive` is the inverse of `baOutEnN` (active low).
- R7: When `abPass` falls while `abClk` stays low, `bOut` holds the `aIn` sampled at the last system edge on which `abPass` was 1.
- R8: If `abPass` is 1 on the same edge that detects a falling `abClk`, storage loads the current `aIn`. After `abPass` drops, `bOut` shows that word.
- R9: Synchronous reset `rst` clears both storage registers to 0 and treats the previous clock samples as 0. A direction clock that is low when reset releases therefore causes no capture.
- R10: A rising edge of a direction clock captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | WIDTH | Word arriving at port A |
| bIn | input | WIDTH | Word arriving at port B |
| abPass | input | 1 | A-to-B pass-through enable |
| abClk | input | 1 | A-to-B capture clock, falling edge |
| abOutEn | input | 1 | Port B drive enable, active high |
| baPass | input | 1 | B-to-A pass-through enable |
| baClk | input | 1 | B-to-A capture clock, falling edge |
| baOutEnN | input | 1 | Port A drive enable, active low |
| bOut | output | WIDTH | Word presented at port B |
| bDrive | output | 1 | Port B drives when 1 |
| aOut | output | WIDTH | Word presented at port A |
| aDrive | output | 1 | Port A drives when 1 |

## Verification
The assertions assume that the direction clocks and pass-through enables are already synchronous to the system clock. They also assume each level lasts at least one system cycle, so a shorter pulse is simply not observed. The stimulus changes every input only on the falling system edge and keeps each level for at least one full cycle. Each falling edge of a direction clock is therefore seen as exactly one 1-then-0 sample pair.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes from a direction controller to its storage path
  typedef struct packed {
    logic pass;     // present input directly
    logic capture;  // load storage at this edge
    logic drive;    // port drive enable, active high
  } dirStrobe_t;
endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
#(
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       passEn,
  input  logic       dirClk,
  input  logic       outEn,
  output dirStrobe_t strb
);
  logic prevClk;
  logic clkFell;

  always_ff @(posedge clk) begin
    if (rst) prevClk <= 1'b0;
    else     prevClk <= dirClk;
  end

  assign clkFell      = prevClk & ~dirClk;
  assign strb.pass    = passEn;
  assign strb.capture = passEn | clkFell;

  generate
    if (OE_ACTIVE_LOW) begin : g_oeLow
      assign strb.drive = ~outEn;
    end else begin : g_oeHigh
      assign strb.drive = outEn;
    end
  endgenerate

  // R4: a 1-then-0 sample pair outside reset must request a capture
  assert_fall_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dirClk) && !dirClk) |-> strb.capture);
  // R10: a rising direction clock alone never captures
  assert_rise_no_capture_R10: assert property (@(posedge clk) disable iff (rst)
    (!passEn && !$past(dirClk) && dirClk) |-> !strb.capture);
endmodule

// File: rtl/xcvr_store_path.sv
module xcvr_store_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  dirStrobe_t       strb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  logic [WIDTH-1:0] store;

  always_ff @(posedge clk) begin
    if (rst)               store <= '0;
    else if (strb.capture) store <= din;
  end

  assign dout  = strb.pass ? din : store;
  assign drive = strb.drive;

  // R3: without a capture strobe the stored word stays put
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> $stable(store));
  // R4: a capture strobe loads the input present at that edge
  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> (store == $past(din)));
  // R9: reset clears storage
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (store == '0));
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             abPass,
  input  logic             abClk,
  input  logic             abOutEn,
  input  logic             baPass,
  input  logic             baClk,
  input  logic             baOutEnN,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive
);
  dirStrobe_t abStrb;
  dirStrobe_t baStrb;

  xcvr_dir_ctrl #(.OE_ACTIVE_LOW(1'b0)) u_abCtrl (
    .clk(clk), .rst(rst), .passEn(abPass), .dirClk(abClk),
    .outEn(abOutEn), .strb(abStrb));

  xcvr_store_path #(.WIDTH(WIDTH)) u_abPath (
    .clk(clk), .rst(rst), .strb(abStrb), .din(aIn),
    .dout(bOut), .drive(bDrive));

  xcvr_dir_ctrl #(.OE_ACTIVE_LOW(1'b1)) u_baCtrl (
    .clk(clk), .rst(rst), .passEn(baPass), .dirClk(baClk),
    .outEn(baOutEnN), .strb(baStrb));

  xcvr_store_path #(.WIDTH(WIDTH)) u_baPath (
    .clk(clk), .rst(rst), .strb(baStrb), .din(bIn),
    .dout(aOut), .drive(aDrive));

  // R2: pass-through presents A at B in the same cycle
  assert_ab_transparent_R2: assert property (@(posedge clk) disable iff (rst)
    abPass |-> (bOut == aIn));
  // R6: the reverse direction is transparent likewise
  assert_ba_transparent_R6: assert property (@(posedge clk) disable iff (rst)
    baPass |-> (aOut == bIn));
endmodule

// File: tb/dual_path_xcvr_tb.sv
module dual_path_xcvr_tb;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic abPass = 1'b0, abClk = 1'b0, abOutEn = 1'b1;
  logic baPass = 1'b0, baClk = 1'b0, baOutEnN = 1'b0;
  logic [W-1:0] bOut, aOut;
  logic bDrive, aDrive;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_path_xcvr #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .abPass(abPass), .abClk(abClk), .abOutEn(abOutEn),
    .baPass(baPass), .baClk(baClk), .baOutEnN(baOutEnN),
    .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive));

  // vector: pass, clk, outEn, aIn, expected bOut, expected bDrive
  typedef struct packed {
    logic         pas;
    logic         ck;
    logic         oe;
    logic [W-1:0] din;
    logic [W-1:0] expOut;
    logic         expDrv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 18'h11111, 18'h00000, 1'b1}, // R9 cleared, no capture
    {1'b0, 1'b1, 1'b1, 18'h22222, 18'h00000, 1'b1}, // R10 rising only
    {1'b0, 1'b0, 1'b1, 18'h33333, 18'h33333, 1'b1}, // R4 falling capture
    {1'b0, 1'b0, 1'b1, 18'h04444, 18'h33333, 1'b1}, // R3 hold clock low
    {1'b1, 1'b0, 1'b1, 18'h05555, 18'h05555, 1'b1}, // R2 transparent
    {1'b1, 1'b0, 1'b1, 18'h06666, 18'h06666, 1'b1}, // R2 transparent
    {1'b0, 1'b0, 1'b1, 18'h07777, 18'h06666, 1'b1}, // R7 pass falls, clk low
    {1'b0, 1'b1, 1'b0, 18'h08888, 18'h06666, 1'b0}, // R5 drive off, R10
    {1'b1, 1'b0, 1'b0, 18'h09999, 18'h09999, 1'b0}, // R8 pass with fall
    {1'b0, 1'b0, 1'b1, 18'h0AAAA, 18'h09999, 1'b1}, // R8 stored word
    {1'b0, 1'b1, 1'b1, 18'h0BBBB, 18'h09999, 1'b1}, // R10 rising
    {1'b0, 1'b1, 1'b1, 18'h0CCCC, 18'h09999, 1'b1}  // R3 hold clock high
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // reset with both direction clocks low
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset bOut", bOut, '0);
    check("R9 reset aOut", aOut, '0);

    // table walk on A-to-B
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      abPass = VEC[i].pas; abClk = VEC[i].ck; abOutEn = VEC[i].oe; aIn = VEC[i].din;
      step();
      check($sformatf("R2/R3/R4/R7/R8/R10 vec %0d bOut", i), bOut, VEC[i].expOut);
      check($sformatf("R5 vec %0d bDrive", i), {{(W-1){1'b0}}, bDrive},
            {{(W-1){1'b0}}, VEC[i].expDrv});
    end
    // R1: B-to-A untouched by all the A-to-B activity
    check("R1 aOut independent", aOut, '0);

    // R6: B-to-A direction, active-low enable
    @(negedge clk); baOutEnN = 1'b1; bIn = 18'h12345;
    step();
    check("R6 aDrive off", {{(W-1){1'b0}}, aDrive}, '0);
    check("R6 aOut hold", aOut, '0);
    @(negedge clk); baClk = 1'b1; baOutEnN = 1'b0;
    step();
    check("R6 aDrive on", {{(W-1){1'b0}}, aDrive}, {{(W-1){1'b0}}, 1'b1});
    @(negedge clk); baClk = 1'b0; bIn = 18'h2ABCD;
    step();
    check("R6 falling capture", aOut, 18'h2ABCD);
    @(negedge clk); baPass = 1'b1; bIn = 18'h01357;
    #1;
    check("R6 transparent same cycle", aOut, 18'h01357);
    step();
    @(negedge clk); baPass = 1'b0; bIn = 18'h3FFFF;
    step();
    check("R6 hold after pass", aOut, 18'h01357);
    check("R1 bOut independent", bOut, 18'h09999);

    // R2: transparency is combinational between edges
    @(negedge clk); abPass = 1'b1; aIn = 18'h2468A;
    #1;
    check("R2 same-cycle transparency", bOut, 18'h2468A);

    // R9: reset mid-run with clock high; release with clock low gives no capture
    @(negedge clk); abPass = 1'b0; abClk = 1'b1; rst = 1'b1;
    step();
    check("R9 reset clears bOut", bOut, '0);
    check("R9 reset clears aOut", aOut, '0);
    @(negedge clk); abClk = 1'b0; aIn = 18'h15555;
    step();
    @(negedge clk); rst = 1'b0;
    step();
    check("R9 no capture after reset", bOut, '0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule